// File: doc/BRIEF.md
# Cross-Trigger Routing Matrix

This block passes debug trigger events between agents on a chip. Each of up to 128 trigger inputs can be mapped onto any of a small set of broadcast channels through its own input mask. Each of up to 128 trigger outputs watches the channels named in its own output mask. When any of those channels is active, the output goes high and stays high until software acknowledges it. Software can also drive channels directly: it can hold channel bits, remove them, or fire them for a single cycle. A gate mask decides which active channels are broadcast onward on the channel outputs.

The block is programmed through a 32-bit APB-style slave that completes every access in a single cycle. Because there can be more than 32 triggers, the trigger status and acknowledge registers are spread over several consecutive words, and each trigger has its own mask word. While the global enable is off, every channel output and trigger output is held at zero, but register writes still take effect.

Top module: `ctm_matrix`

## Requirements
- R1: After reset, these registers read as follows: control 0, held software channels 0, gate all ones over the channel width, every mask 0, and the SoC control word 0. Both `trig_out_o` and `chan_out_o` are 0.
- R2: While control bit 0 is 0, `trig_out_o` and `chan_out_o` are 0, and any latched trigger outputs are cleared. Register writes are still stored and can be read back.
- R3: A write to 0x004 ORs the written channel bits into the held software channel value. A write to 0x008 removes the written bits. A read of 0x004 returns the held value. While enabled, every held bit keeps its channel active.
- R4: A write to 0x00C makes the written channels active for exactly one cycle and also removes those bits from the held value.
- R5: When the block is enabled, trigger input t drives every channel c that has bit c set in its input mask. Trigger output t goes high on the clock edge after any channel in its output mask becomes active.
- R6: Gate bit c set to 0 forces `chan_out_o[c]` to 0. That channel still drives local trigger outputs.
- R7: A trigger output stays high after its cause goes away. Writing 1 to bit j of word 0x020+4*w clears trigger 32*w+j and no other trigger. If the cause is still present in the same cycle, the output stays high.
- R8: Word 0x040+4*w returns trigger inputs 32*w to 32*w+31, and word 0x060+4*w returns the latched trigger outputs for the same range. Bit j holds trigger 32*w+j. Bits beyond the trigger count read 0.
- R9: Offset 0x080 returns the channels driven by enabled trigger inputs only, excluding software bits. Offset 0x084 returns `chan_out_o`.
- R10: Reads of unmapped offsets return 0 and writes to them are ignored. This includes mask words whose trigger index is at or beyond the trigger count, and status words beyond the last one.
- R11: Offset 0x08C is a 32-bit read/write word that drives `soc_ctl_o`.
- R12: The input mask of trigger n is at 0x400+4*n and the output mask at 0x800+4*n. Each mask stores only the low channel-count bits, and reads return 0 above them. The gate register at 0x088 likewise uses only the low channel-count bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase |
| pwrite_i | input | 1 | 1 for write |
| paddr_i | input | 12 | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, combinational from address |
| trig_in_i | input | NUM_TRIG | Trigger inputs |
| trig_out_o | output | NUM_TRIG | Latched trigger outputs |
| chan_out_o | output | NUM_CHAN | Gated channels broadcast onward |
| soc_ctl_o | output | 32 | SoC control word |

## Verification
The bench builds the block with 40 triggers and 4 channels. With 40 triggers, the status and acknowledge registers span two words and the second word is only partly filled. That configuration makes it possible to test the zeroed high bits, the first status word past the end, and mask indices 40 and above, all of which must read as unmapped. It also makes it possible to acknowledge a trigger in the second word and confirm that an acknowledge written to the wrong word has no effect on it.

// File: rtl/ctm_pkg.sv
`timescale 1ns/1ps
package ctm_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [11:0] A_CTRL  = 12'h000;
  localparam logic [11:0] A_SET   = 12'h004;
  localparam logic [11:0] A_CLR   = 12'h008;
  localparam logic [11:0] A_PULSE = 12'h00C;
  localparam logic [11:0] A_ACK   = 12'h020;
  localparam logic [11:0] A_TIN   = 12'h040;
  localparam logic [11:0] A_TOUT  = 12'h060;
  localparam logic [11:0] A_CHIN  = 12'h080;
  localparam logic [11:0] A_CHOUT = 12'h084;
  localparam logic [11:0] A_GATE  = 12'h088;
  localparam logic [11:0] A_SOC   = 12'h08C;

  localparam logic [1:0] PAGE_INEN  = 2'b01;
  localparam logic [1:0] PAGE_OUTEN = 2'b10;

  function automatic int unsigned n_words(int unsigned n);
    return (n + 31) / 32;
  endfunction
endpackage

// File: rtl/ctm_regs.sv
`timescale 1ns/1ps
module ctm_regs
  import ctm_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 128,
  parameter int unsigned NUM_CHAN = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               psel_i,
  input  logic                               penable_i,
  input  logic                               pwrite_i,
  input  logic [ADDR_W-1:0]                  paddr_i,
  input  logic [31:0]                        pwdata_i,
  output logic [31:0]                        prdata_o,
  input  logic [NUM_TRIG-1:0]                trig_in_i,
  input  logic [NUM_TRIG-1:0]                trig_out_i,
  input  logic [NUM_CHAN-1:0]                chan_in_st_i,
  input  logic [NUM_CHAN-1:0]                chan_out_i,
  output logic                               en_o,
  output logic [NUM_CHAN-1:0]                app_o,
  output logic [NUM_CHAN-1:0]                pulse_o,
  output logic [NUM_CHAN-1:0]                gate_o,
  output logic [31:0]                        soc_o,
  output logic [NUM_TRIG-1:0][NUM_CHAN-1:0]  inen_o,
  output logic [NUM_TRIG-1:0][NUM_CHAN-1:0]  outen_o,
  output logic [NUM_TRIG-1:0]                ack_o
);
  localparam int unsigned NW  = n_words(NUM_TRIG);
  localparam int unsigned PAD = NW * 32;
  localparam int unsigned IW  = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  logic                              wr;
  logic [7:0]                        idx;
  logic                              idx_ok;
  logic [IW-1:0]                     tsel;
  logic [1:0]                        page;
  logic                              en_q;
  logic [NUM_CHAN-1:0]               app_q, pulse_q, gate_q;
  logic [31:0]                       soc_q;
  logic [NUM_TRIG-1:0][NUM_CHAN-1:0] inen_q, outen_q;
  logic [PAD-1:0]                    tin_pad, tout_pad;
  logic [NUM_CHAN-1:0]               wchan;

  assign wr     = psel_i & penable_i & pwrite_i;
  assign idx    = paddr_i[9:2];
  assign page   = paddr_i[11:10];
  assign idx_ok = ({24'd0, idx} < 32'(NUM_TRIG)) && (paddr_i[1:0] == 2'b00);
  assign tsel   = idx[IW-1:0];
  assign wchan  = pwdata_i[NUM_CHAN-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      app_q   <= '0;
      pulse_q <= '0;
      gate_q  <= '1;
      soc_q   <= '0;
      inen_q  <= '0;
      outen_q <= '0;
    end else begin
      pulse_q <= (wr && paddr_i == A_PULSE) ? wchan : '0;
      if (wr) begin
        if (paddr_i == A_CTRL)  en_q   <= pwdata_i[0];
        if (paddr_i == A_SET)   app_q  <= app_q | wchan;
        if (paddr_i == A_CLR)   app_q  <= app_q & ~wchan;
        if (paddr_i == A_PULSE) app_q  <= app_q & ~wchan;
        if (paddr_i == A_GATE)  gate_q <= wchan;
        if (paddr_i == A_SOC)   soc_q  <= pwdata_i;
        if (idx_ok && page == PAGE_INEN)  inen_q[tsel]  <= wchan;
        if (idx_ok && page == PAGE_OUTEN) outen_q[tsel] <= wchan;
      end
    end
  end

  // acknowledge strobes, one bit per trigger, word chosen by trigger index
  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_ack
    localparam logic [11:0] AW = A_ACK + 12'(4 * (t / 32));
    assign ack_o[t] = wr && (paddr_i == AW) && pwdata_i[t % 32];
  end

  always_comb begin
    tin_pad  = '0;
    tout_pad = '0;
    tin_pad[NUM_TRIG-1:0]  = trig_in_i;
    tout_pad[NUM_TRIG-1:0] = trig_out_i;
  end

  always_comb begin
    prdata_o = '0;
    case (paddr_i)
      A_CTRL:  prdata_o = {31'd0, en_q};
      A_SET:   prdata_o = 32'(app_q);
      A_CHIN:  prdata_o = 32'(chan_in_st_i);
      A_CHOUT: prdata_o = 32'(chan_out_i);
      A_GATE:  prdata_o = 32'(gate_q);
      A_SOC:   prdata_o = soc_q;
      default: prdata_o = '0;
    endcase
    for (int w = 0; w < int'(NW); w++) begin
      if (paddr_i == A_TIN  + 12'(4 * w)) prdata_o = tin_pad[32*w +: 32];
      if (paddr_i == A_TOUT + 12'(4 * w)) prdata_o = tout_pad[32*w +: 32];
    end
    if (idx_ok && page == PAGE_INEN)  prdata_o = 32'(inen_q[tsel]);
    if (idx_ok && page == PAGE_OUTEN) prdata_o = 32'(outen_q[tsel]);
  end

  assign en_o    = en_q;
  assign app_o   = app_q;
  assign pulse_o = pulse_q;
  assign gate_o  = gate_q;
  assign soc_o   = soc_q;
  assign inen_o  = inen_q;
  assign outen_o = outen_q;

  AST_PULSE_DROPS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && paddr_i == A_PULSE) |=> ((app_q & $past(wchan)) == '0)) else $error("pulse left held bits"); // R4
  AST_SET_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && paddr_i == A_SET) |=> ((app_q & $past(wchan)) == $past(wchan))) else $error("set not held"); // R3
endmodule

// File: rtl/ctm_route.sv
`timescale 1ns/1ps
module ctm_route #(
  parameter int unsigned NUM_TRIG = 128,
  parameter int unsigned NUM_CHAN = 4
) (
  input  logic                               en_i,
  input  logic [NUM_TRIG-1:0]                trig_in_i,
  input  logic [NUM_TRIG-1:0][NUM_CHAN-1:0]  inen_i,
  input  logic [NUM_TRIG-1:0][NUM_CHAN-1:0]  outen_i,
  input  logic [NUM_CHAN-1:0]                app_i,
  input  logic [NUM_CHAN-1:0]                pulse_i,
  input  logic [NUM_CHAN-1:0]                gate_i,
  output logic [NUM_CHAN-1:0]                chan_in_st_o,
  output logic [NUM_CHAN-1:0]                chan_out_o,
  output logic [NUM_TRIG-1:0]                hit_o
);
  logic [NUM_CHAN-1:0] raw, chan_act;

  always_comb begin
    raw = '0;
    for (int t = 0; t < int'(NUM_TRIG); t++)
      raw |= inen_i[t] & {NUM_CHAN{trig_in_i[t]}};
  end

  assign chan_act     = en_i ? (raw | app_i | pulse_i) : '0;
  assign chan_in_st_o = en_i ? raw : '0;
  assign chan_out_o   = chan_act & gate_i;

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_hit
    assign hit_o[t] = |(chan_act & outen_i[t]);
  end
endmodule

// File: rtl/ctm_trig_latch.sv
`timescale 1ns/1ps
module ctm_trig_latch #(
  parameter int unsigned NUM_TRIG = 128
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [NUM_TRIG-1:0] hit_i,
  input  logic [NUM_TRIG-1:0] ack_i,
  output logic [NUM_TRIG-1:0] trig_o
);
  logic [NUM_TRIG-1:0] q;

  // new event wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (!en_i) q <= '0;
    else            q <= (q & ~ack_i) | hit_i;
  end

  assign trig_o = q & {NUM_TRIG{en_i}};

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_chk
    AST_EVENT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && hit_i[t]) |=> q[t]) else $error("event not latched"); // R5
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && q[t] && !ack_i[t]) |=> q[t]) else $error("latch dropped"); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && q[t] && ack_i[t] && !hit_i[t]) |=> !q[t]) else $error("ack ignored"); // R7
  end
endmodule

// File: rtl/ctm_matrix.sv
`timescale 1ns/1ps
module ctm_matrix
  import ctm_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 128,
  parameter int unsigned NUM_CHAN = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                psel_i,
  input  logic                penable_i,
  input  logic                pwrite_i,
  input  logic [ADDR_W-1:0]   paddr_i,
  input  logic [31:0]         pwdata_i,
  output logic [31:0]         prdata_o,
  input  logic [NUM_TRIG-1:0] trig_in_i,
  output logic [NUM_TRIG-1:0] trig_out_o,
  output logic [NUM_CHAN-1:0] chan_out_o,
  output logic [31:0]         soc_ctl_o
);
  logic                              en;
  logic [NUM_CHAN-1:0]               app, pulse, gate, chan_in_st;
  logic [NUM_TRIG-1:0][NUM_CHAN-1:0] inen, outen;
  logic [NUM_TRIG-1:0]               ack, hit;

  ctm_regs #(.NUM_TRIG(NUM_TRIG), .NUM_CHAN(NUM_CHAN)) u_regs (
    .clk_i, .rst_ni, .psel_i, .penable_i, .pwrite_i, .paddr_i, .pwdata_i, .prdata_o,
    .trig_in_i, .trig_out_i(trig_out_o), .chan_in_st_i(chan_in_st), .chan_out_i(chan_out_o),
    .en_o(en), .app_o(app), .pulse_o(pulse), .gate_o(gate), .soc_o(soc_ctl_o),
    .inen_o(inen), .outen_o(outen), .ack_o(ack)
  );

  ctm_route #(.NUM_TRIG(NUM_TRIG), .NUM_CHAN(NUM_CHAN)) u_route (
    .en_i(en), .trig_in_i, .inen_i(inen), .outen_i(outen), .app_i(app), .pulse_i(pulse),
    .gate_i(gate), .chan_in_st_o(chan_in_st), .chan_out_o, .hit_o(hit)
  );

  ctm_trig_latch #(.NUM_TRIG(NUM_TRIG)) u_latch (
    .clk_i, .rst_ni, .en_i(en), .hit_i(hit), .ack_i(ack), .trig_o(trig_out_o)
  );

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (trig_out_o == '0 && chan_out_o == '0)) else $error("active while disabled"); // R2
  AST_GATE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_out_o & ~gate) == '0) else $error("gated channel broadcast"); // R6
  AST_SWCH_NOT_IN_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_in_st & ~chan_out_o & gate) == '0) else $error("status channel not broadcast"); // R9
endmodule

// File: tb/ctm_matrix_tb.sv
`timescale 1ns/1ps
module ctm_matrix_tb;
  localparam int NT = 40;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [NT-1:0] trig_in = '0;
  logic [NT-1:0] trig_out;
  logic [NC-1:0] chan_out;
  logic [31:0] soc_ctl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [NC-1:0] m_inen [NT];
  logic [NC-1:0] m_outen [NT];
  logic [NC-1:0] m_gate;
  logic [NT-1:0] m_latch;

  always #4 clk = ~clk;

  ctm_matrix #(.NUM_TRIG(NT), .NUM_CHAN(NC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .trig_in_i(trig_in),
    .trig_out_o(trig_out), .chan_out_o(chan_out), .soc_ctl_o(soc_ctl)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [NC-1:0] f_chan(logic [NT-1:0] tin);
    logic [NC-1:0] r = '0;
    for (int t = 0; t < NT; t++) if (tin[t]) r |= m_inen[t];
    return r;
  endfunction

  function automatic logic [NT-1:0] f_hit(logic [NT-1:0] tin);
    logic [NT-1:0] h;
    logic [NC-1:0] c = f_chan(tin);
    for (int t = 0; t < NT; t++) h[t] = |(c & m_outen[t]);
    return h;
  endfunction

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    logic [NT-1:0] tin;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 trig_out", 64'(trig_out), 0);
    chk("R1 chan_out", 64'(chan_out), 0);
    chk("R1 soc", 64'(soc_ctl), 0);
    rd(12'h000, d); chk("R1 ctrl", 64'(d), 0);
    rd(12'h088, d); chk("R1 gate", 64'(d), 64'hF);
    rd(12'h004, d); chk("R1 held", 64'(d), 0);
    rd(12'h400, d); chk("R1 inen0", 64'(d), 0);

    // R12 mask width and placement
    wr(12'h40C, 32'hFFFF_FFFF); rd(12'h40C, d); chk("R12 inen3 width", 64'(d), 64'hF);
    wr(12'h40C, 0);
    wr(12'h800, 1); wr(12'h804, 2); wr(12'h808, 4); wr(12'h80C, 8);
    rd(12'h80C, d); chk("R12 outen3", 64'(d), 64'h8);

    // R10 unmapped
    rd(12'h0F0, d); chk("R10 unmapped read", 64'(d), 0);
    wr(12'h0F0, 32'h1234); rd(12'h0F0, d); chk("R10 unmapped write", 64'(d), 0);
    wr(12'h4A0, 32'hF); rd(12'h4A0, d); chk("R10 inen index 40", 64'(d), 0);
    rd(12'h048, d); chk("R10 status word 2", 64'(d), 0);

    // R11 soc word
    wr(12'h08C, 32'hA5A5_1234);
    chk("R11 soc_ctl_o", 64'(soc_ctl), 64'hA5A5_1234);
    rd(12'h08C, d); chk("R11 readback", 64'(d), 64'hA5A5_1234);

    // R2 / R3 software channels while disabled, then enabled
    wr(12'h004, 1); settle();
    chk("R2 chan_out disabled", 64'(chan_out), 0);
    chk("R2 trig_out disabled", 64'(trig_out), 0);
    rd(12'h004, d); chk("R3 set", 64'(d), 64'h1);
    wr(12'h004, 2); rd(12'h004, d); chk("R3 set or", 64'(d), 64'h3);
    wr(12'h008, 1); rd(12'h004, d); chk("R3 clear", 64'(d), 64'h2);
    wr(12'h000, 1); settle();
    chk("R3 chan_out held", 64'(chan_out), 64'h2);
    chk("R5 trig_out from sw channel", 64'(trig_out), 64'h2);
    wr(12'h008, 2); settle();
    chk("R3 chan_out cleared", 64'(chan_out), 0);
    chk("R7 latch holds", 64'(trig_out), 64'h2);
    wr(12'h020, 2); settle();
    chk("R7 ack clears", 64'(trig_out), 0);

    // R4 pulse, R7 event beats ack
    wr(12'h004, 8); settle();
    chk("R5 trig3", 64'(trig_out), 64'h8);
    wr(12'h020, 8); settle();
    chk("R7 ack with event present", 64'(trig_out), 64'h8);
    wr(12'h00C, 32'hC); settle();
    rd(12'h004, d); chk("R4 pulse drops held", 64'(d), 0);
    chk("R4 pulse latches", 64'(trig_out), 64'hC);
    chk("R4 pulse one cycle", 64'(chan_out), 0);
    wr(12'h020, 32'hF); settle();
    chk("R7 ack all", 64'(trig_out), 0);

    // R6 gate
    wr(12'h088, 32'hE); wr(12'h004, 1); settle();
    chk("R6 gated chan_out", 64'(chan_out), 0);
    chk("R6 local trigger still", 64'(trig_out), 64'h1);
    rd(12'h084, d); chk("R9 chan-out status gated", 64'(d), 0);
    rd(12'h080, d); chk("R9 chan-in excludes sw", 64'(d), 0);
    wr(12'h008, 1); wr(12'h020, 1); wr(12'h088, 32'hF); settle();

    // R9 channel status from trigger input, R7 word selection
    wr(12'h414, 2);
    wr(12'h48C, 1);               // inen[35] = ch0
    wr(12'h884, 1);               // outen[33] = ch0
    trig_in = NT'(1) << 5; settle();
    rd(12'h080, d); chk("R9 chan-in", 64'(d), 64'h2);
    rd(12'h084, d); chk("R9 chan-out", 64'(d), 64'h2);
    chk("R5 input route", 64'(trig_out), 64'h2);
    trig_in = NT'(1) << 35; settle();
    chk("R5 second word route", 64'(trig_out), (64'h1 << 33) | 64'h3);
    rd(12'h064, d); chk("R8 tout word1", 64'(d), 64'h2);
    rd(12'h044, d); chk("R8 tin word1", 64'(d), 64'h8);
    trig_in = '0; settle();
    wr(12'h020, 32'h3); settle();
    chk("R7 wrong word no effect", 64'(trig_out), 64'h1 << 33);
    wr(12'h024, 32'h2); settle();
    chk("R7 word1 ack", 64'(trig_out), 0);

    // R2 disable clears latches, writes still taken
    trig_in = NT'(1) << 35; settle();
    trig_in = '0;
    wr(12'h000, 0); settle();
    chk("R2 disabled trig_out", 64'(trig_out), 0);
    chk("R2 disabled chan_out", 64'(chan_out), 0);
    wr(12'h418, 3); rd(12'h418, d); chk("R2 write while disabled", 64'(d), 64'h3);
    wr(12'h000, 1); settle();
    chk("R2 latches cleared on disable", 64'(trig_out), 0);

    // random routing
    for (int it = 0; it < 12; it++) begin
      wr(12'h000, 0);
      m_latch = '0;
      for (int t = 0; t < NT; t++) begin
        m_inen[t]  = NC'($urandom_range(0, 15));
        m_outen[t] = NC'($urandom_range(0, 15));
        wr(12'h400 + 12'(4 * t), 32'(m_inen[t]) | ($urandom & 32'hFFF0_0000));
        wr(12'h800 + 12'(4 * t), 32'(m_outen[t]));
      end
      m_gate = NC'($urandom_range(0, 15));
      wr(12'h088, 32'(m_gate));
      wr(12'h000, 1);
      tin = '0;
      for (int t = 0; t < NT; t++) tin[t] = ($urandom_range(0, 5) == 0);
      trig_in = tin; settle();
      m_latch = f_hit(tin);
      chk("R5 random trig_out", 64'(trig_out), 64'(m_latch));
      chk("R6 random chan_out", 64'(chan_out), 64'(f_chan(tin) & m_gate));
      rd(12'h080, d); chk("R9 random chan-in", 64'(d), 64'(f_chan(tin)));
      rd(12'h040, d); chk("R8 tin word0", 64'(d), 64'(tin[31:0]));
      rd(12'h044, d); chk("R8 tin word1", 64'(d), 64'(tin[NT-1:32]));
      rd(12'h060, d); chk("R8 tout word0", 64'(d), 64'(m_latch[31:0]));
      rd(12'h064, d); chk("R8 tout word1", 64'(d), 64'(m_latch[NT-1:32]));
      trig_in = '0; settle();
      chk("R7 random hold", 64'(trig_out), 64'(m_latch));
      wr(12'h020, 32'hFFFF_FFFF); wr(12'h024, 32'hFFFF_FFFF); settle();
      chk("R7 random ack", 64'(trig_out), 0);
    end

    done = 1;
    summary();
  end
endmodule